// File: doc/BRIEF.md
# I2C-over-AUX Byte Transaction Sequencer

This block carries one I2C byte operation over an auxiliary-channel transport: a plain read, a plain write, or either one marked as a start or stop. A command is accepted with a 3-bit operation code, a 16-bit address and a write byte. The block packs these into a request header and hands it to a separate AUX transmit/receive engine through a valid/ready handshake. It then waits for that engine's response and decodes the reply status in two levels: first the native link field, then the I2C field.

Deferred replies are retried after a back-off window. The window is measured in ticks of a prescaled counter, and the native and I2C levels have different window lengths. A busy transport is retried at once. Every attempt draws on one shared budget. The result is reported as a one-cycle `done` pulse with a result code. For a plain read that succeeds, the received byte is also reported.

Operation code bits: bit 0 set means read (clear means write), bit 1 marks start, bit 2 marks stop. Result codes: 0 ok, 1 native NACK, 2 I2C NACK, 3 invalid reply, 4 transport error, 5 retries exhausted.

Top module: `aux_i2c_byte_seq`

## Requirements
- R1: Request byte 0 (`req_bytes[7:0]`) is the address low byte and byte 1 is the address high byte. Byte 2 holds the request code in its upper nibble: 0 for write, 1 for read, plus 4 when the middle-of-transaction flag is set.
- R2: A plain read sends `req_len`=4 with byte 3 = 0x40 and byte 4 = 0x00. A plain write sends `req_len`=5 with byte 3 = 0x50 and byte 4 = the write byte.
- R3: When start or stop is set in the operation code, byte 3 is 0x30 (address-only marker). `req_len` keeps its read/write value.
- R4: The middle-of-transaction flag (bit 6 of byte 2) is set for every operation except one with the stop bit.
- R5: `busy` rises in the cycle after a command is accepted in idle. It stays high until the cycle in which `done` pulses, where it is low. A `cmd_valid` seen while busy is ignored.
- R6: A response with `rsp_err`=1 (busy) resends the request in the very next cycle. Any other nonzero `rsp_err` ends the command with result 4.
- R7: With `rsp_err`=0, the native field is status bits [5:4]. A value of 1 ends with result 2'd1 (native NACK). A value of 2 defers and retries after NATIVE_WAIT ticks. A value of 3 ends with result 3. A value of 0 goes on to the I2C field.
- R8: The I2C field is status bits [7:6]. A value of 0 ends with result 0. A value of 1 ends with result 2. A value of 2 defers and retries after I2C_WAIT ticks. A value of 3 ends with result 3.
- R9: At most MAX_TRIES requests are sent per command. A retry that would exceed the budget ends the command with result 5.
- R10: After a defer, the next request appears exactly wait×TICK_DIV+1 cycles after the cycle in which the response was presented. After a busy response, it appears 1 cycle later.
- R11: `rdata` is updated only on result 0 of a read with neither start nor stop. Writes and start/stop reads leave it unchanged.
- R12: While `req_valid` is high and `req_ready` low, `req_valid` stays high and `req_bytes` stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, taken only when idle |
| cmd_op | input | 3 | Operation: bit0 read, bit1 start, bit2 stop |
| cmd_addr | input | 16 | Target address |
| cmd_wdata | input | 8 | Byte to write |
| busy | output | 1 | Command in progress |
| req_valid | output | 1 | Request header offered to the transport |
| req_ready | input | 1 | Transport takes the request |
| req_bytes | output | 40 | Request bytes, byte k at bits 8k+7:8k |
| req_len | output | 3 | Number of request bytes (4 or 5) |
| rsp_valid | input | 1 | Transport response strobe |
| rsp_err | input | 2 | 0 none, 1 busy, 2/3 error |
| rsp_status | input | 8 | Reply status byte |
| rsp_data | input | 8 | First reply data byte |
| done | output | 1 | One-cycle result strobe |
| result | output | 3 | Result code |
| rdata | output | 8 | Last byte read |

## Verification
A wrong attempt counter shows up as the wrong number of requests reaching the transport before `done`. A wrong retry decision shows up as the wrong result code on the same command. A prescaler or tick counter that is off by one moves the next `req_valid` edge by one or more cycles, and this is visible on the first retry after a defer. A mislatched operation code corrupts the header bytes on the first request, within two cycles of the command. A mis-gated read latch leaves `rdata` holding the wrong byte at the `done` pulse of a start/stop read.

// File: rtl/aux_i2c_pkg.sv
package aux_i2c_pkg;
  localparam int OP_RD    = 0;
  localparam int OP_START = 1;
  localparam int OP_STOP  = 2;

  typedef enum logic [2:0] {
    RES_OK          = 3'd0,
    RES_NATIVE_NACK = 3'd1,
    RES_I2C_NACK    = 3'd2,
    RES_INVALID     = 3'd3,
    RES_XPORT       = 3'd4,
    RES_GIVE_UP     = 3'd5
  } res_e;

  typedef enum logic [1:0] {
    ACT_DONE, ACT_RETRY_NOW, ACT_WAIT_NATIVE, ACT_WAIT_I2C
  } act_e;

  typedef enum logic [1:0] {S_IDLE, S_SEND, S_WAIT, S_HOLD} st_e;

  // request code nibble: write 0, read 1, middle-of-transaction adds 4
  function automatic logic [7:0] req_code_byte(input logic [2:0] op);
    logic [3:0] code;
    code = {1'b0, !op[OP_STOP], 1'b0, op[OP_RD]};
    return {code, 4'h0};
  endfunction

  function automatic logic [7:0] len_field_byte(input logic [2:0] op);
    if (op[OP_START] || op[OP_STOP]) return 8'h30;
    return op[OP_RD] ? 8'h40 : 8'h50;
  endfunction
endpackage

// File: rtl/aux_i2c_hdr.sv
module aux_i2c_hdr
  import aux_i2c_pkg::*;
(
  input  logic [2:0]  op,
  input  logic [15:0] addr,
  input  logic [7:0]  wdata,
  output logic [39:0] bytes,
  output logic [2:0]  len
);
  always_comb begin
    bytes[7:0]   = addr[7:0];
    bytes[15:8]  = addr[15:8];
    bytes[23:16] = req_code_byte(op);
    bytes[31:24] = len_field_byte(op);
    bytes[39:32] = op[OP_RD] ? 8'h00 : wdata;
    len          = op[OP_RD] ? 3'd4 : 3'd5;
  end
endmodule

// File: rtl/aux_reply_decode.sv
module aux_reply_decode
  import aux_i2c_pkg::*;
(
  input  logic [1:0] xp_err,
  input  logic [7:0] status,
  output act_e       act,
  output res_e       res
);
  logic [1:0] native_f, i2c_f;
  assign native_f = status[5:4];
  assign i2c_f    = status[7:6];

  always_comb begin
    act = ACT_DONE;
    res = RES_INVALID;
    if (xp_err == 2'd1) begin
      act = ACT_RETRY_NOW;
      res = RES_GIVE_UP;
    end else if (xp_err != 2'd0) begin
      res = RES_XPORT;
    end else begin
      case (native_f)
        2'd1: res = RES_NATIVE_NACK;
        2'd2: act = ACT_WAIT_NATIVE;
        2'd3: res = RES_INVALID;
        default: begin
          case (i2c_f)
            2'd0: res = RES_OK;
            2'd1: res = RES_I2C_NACK;
            2'd2: act = ACT_WAIT_I2C;
            default: res = RES_INVALID;
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/aux_backoff_timer.sv
module aux_backoff_timer #(
  parameter int TICK_DIV = 250,
  parameter int TICKS_W  = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [TICKS_W-1:0] ticks,
  output logic               expired
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(TICK_DIV - 1);

  logic               running;
  logic [PRE_W-1:0]   pre;
  logic [TICKS_W-1:0] cnt;

  assign expired = running && (pre == '0) && (cnt <= TICKS_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      pre     <= '0;
      cnt     <= '0;
    end else if (start) begin
      running <= 1'b1;
      pre     <= PRE_MAX;
      cnt     <= ticks;
    end else if (running) begin
      if (pre == '0) begin
        if (cnt <= TICKS_W'(1)) running <= 1'b0;
        else begin
          cnt <= cnt - 1'b1;
          pre <= PRE_MAX;
        end
      end else begin
        pre <= pre - 1'b1;
      end
    end
  end
endmodule

// File: rtl/aux_i2c_byte_seq.sv
module aux_i2c_byte_seq
  import aux_i2c_pkg::*;
#(
  parameter int TICK_DIV    = 250,
  parameter int NATIVE_WAIT = 500,
  parameter int I2C_WAIT    = 400,
  parameter int MAX_TRIES   = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_valid,
  input  logic [2:0]  cmd_op,
  input  logic [15:0] cmd_addr,
  input  logic [7:0]  cmd_wdata,
  output logic        busy,
  output logic        req_valid,
  input  logic        req_ready,
  output logic [39:0] req_bytes,
  output logic [2:0]  req_len,
  input  logic        rsp_valid,
  input  logic [1:0]  rsp_err,
  input  logic [7:0]  rsp_status,
  input  logic [7:0]  rsp_data,
  output logic        done,
  output logic [2:0]  result,
  output logic [7:0]  rdata
);
  localparam int WAIT_MAX = (NATIVE_WAIT > I2C_WAIT) ? NATIVE_WAIT : I2C_WAIT;
  localparam int TICKS_W  = $clog2(WAIT_MAX + 1);
  localparam int TRY_W    = $clog2(MAX_TRIES + 1);

  st_e              state;
  logic [2:0]       op_q;
  logic [39:0]      hdr_q;
  logic [2:0]       len_q;
  logic [TRY_W-1:0] tries;
  logic             done_q;
  logic [2:0]       result_q;
  logic [7:0]       rdata_q;

  logic [39:0] hdr_d;
  logic [2:0]  len_d;
  act_e        act;
  res_e        dec_res;
  logic        wait_expired;

  // named internal events
  logic accept, sent, got_rsp, out_of_tries, retry_now, start_wait, finish, latch_rd;
  logic [TICKS_W-1:0] wait_ticks;

  aux_i2c_hdr u_hdr (
    .op(cmd_op), .addr(cmd_addr), .wdata(cmd_wdata), .bytes(hdr_d), .len(len_d)
  );

  aux_reply_decode u_dec (
    .xp_err(rsp_err), .status(rsp_status), .act(act), .res(dec_res)
  );

  aux_backoff_timer #(.TICK_DIV(TICK_DIV), .TICKS_W(TICKS_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(start_wait), .ticks(wait_ticks),
    .expired(wait_expired)
  );

  assign accept       = cmd_valid && (state == S_IDLE);
  assign sent         = (state == S_SEND) && req_ready;
  assign got_rsp      = (state == S_WAIT) && rsp_valid;
  assign out_of_tries = tries >= TRY_W'(MAX_TRIES);
  assign retry_now    = got_rsp && (act == ACT_RETRY_NOW) && !out_of_tries;
  assign start_wait   = got_rsp && ((act == ACT_WAIT_NATIVE) || (act == ACT_WAIT_I2C))
                        && !out_of_tries;
  assign finish       = got_rsp && !retry_now && !start_wait;
  assign latch_rd     = finish && (act == ACT_DONE) && (dec_res == RES_OK)
                        && (op_q == 3'b001);
  assign wait_ticks   = (act == ACT_WAIT_NATIVE) ? TICKS_W'(NATIVE_WAIT)
                                                 : TICKS_W'(I2C_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      op_q     <= '0;
      hdr_q    <= '0;
      len_q    <= '0;
      tries    <= '0;
      done_q   <= 1'b0;
      result_q <= '0;
      rdata_q  <= '0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          state <= S_SEND;
          op_q  <= cmd_op;
          hdr_q <= hdr_d;
          len_q <= len_d;
          tries <= '0;
        end
        S_SEND: if (sent) begin
          state <= S_WAIT;
          tries <= tries + 1'b1;
        end
        S_WAIT: if (got_rsp) begin
          if (retry_now) state <= S_SEND;
          else if (start_wait) state <= S_HOLD;
          else begin
            state    <= S_IDLE;
            done_q   <= 1'b1;
            result_q <= (act == ACT_DONE) ? dec_res : RES_GIVE_UP;
          end
        end
        default: if (wait_expired) state <= S_SEND;
      endcase
      if (latch_rd) rdata_q <= rsp_data;
    end
  end

  assign busy      = (state != S_IDLE);
  assign req_valid = (state == S_SEND);
  assign req_bytes = hdr_q;
  assign req_len   = len_q;
  assign done      = done_q;
  assign result    = result_q;
  assign rdata     = rdata_q;
endmodule

// File: rtl/aux_i2c_seq_chk.sv
module aux_i2c_seq_chk #(
  parameter int MAX_TRIES = 7
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic [2:0]  cmd_op,
  input logic        busy,
  input logic        req_valid,
  input logic        req_ready,
  input logic [39:0] req_bytes,
  input logic        done,
  input logic        wait_expired
);
  logic [2:0] op_seen;
  logic [7:0] attempts;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_seen  <= '0;
      attempts <= '0;
    end else if (cmd_valid && !busy) begin
      op_seen  <= cmd_op;
      attempts <= '0;
    end else if (req_valid && req_ready) begin
      attempts <= attempts + 8'd1;
    end
  end

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_bytes)); // R12
  AST_TRY_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    attempts <= 8'(MAX_TRIES)); // R9
  AST_LEN_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_bytes[31:28] == 4'd3 || req_bytes[31:28] == 4'd4
                   || req_bytes[31:28] == 4'd5)); // R2
  AST_MOT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_bytes[22] == !op_seen[2]); // R4
  AST_START_STOP_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (op_seen[1] || op_seen[2]) |-> req_bytes[31:24] == 8'h30); // R3
  AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R5
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !req_valid); // R5
  AST_WAIT_THEN_SEND: assert property (@(posedge clk) disable iff (!rst_n)
    wait_expired |=> req_valid); // R10
endmodule

bind aux_i2c_byte_seq aux_i2c_seq_chk #(.MAX_TRIES(MAX_TRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .busy(busy), .req_valid(req_valid), .req_ready(req_ready),
  .req_bytes(req_bytes), .done(done), .wait_expired(wait_expired)
);

// File: tb/aux_i2c_byte_seq_tb.sv
`timescale 1ns/1ps
module aux_i2c_byte_seq_tb;
  localparam int TD = 3, NW = 4, IW = 2, MT = 7;
  localparam int GN = NW * TD, GI = IW * TD;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_op = '0;
  logic [15:0] cmd_addr = '0;
  logic [7:0] cmd_wdata = '0;
  logic busy, req_valid, done;
  logic req_ready = 1'b0, rsp_valid = 1'b0;
  logic [39:0] req_bytes;
  logic [2:0] req_len, result;
  logic [1:0] rsp_err = '0;
  logic [7:0] rsp_status = '0, rsp_data = '0, rdata;

  aux_i2c_byte_seq #(.TICK_DIV(TD), .NATIVE_WAIT(NW), .I2C_WAIT(IW), .MAX_TRIES(MT)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy),
    .req_valid(req_valid), .req_ready(req_ready), .req_bytes(req_bytes),
    .req_len(req_len), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_status(rsp_status), .rsp_data(rsp_data), .done(done),
    .result(result), .rdata(rdata)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, errors = 0;
  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  typedef struct { logic [1:0] err; logic [7:0] st; logic [7:0] dat; int gap; } rsp_t;
  typedef struct { logic [2:0] res; logic [7:0] rd; string tag; } exp_t;
  rsp_t rq[$];
  exp_t eq[$];
  logic [39:0] exp_hdr;
  logic [2:0]  exp_len;
  string cur_tag = "";
  int nreq = 0, next_gap = -1, last_rsp_cyc = 0;

  // transport model: checks headers and retry spacing
  initial begin
    forever begin
      if (req_valid === 1'b1) begin
        rsp_t r;
        nreq++;
        if (next_gap >= 0) chk(cyc - last_rsp_cyc == next_gap + 1,
                               {"R10 R6 spacing ", cur_tag}, cyc - last_rsp_cyc, next_gap + 1);
        chk(req_bytes == exp_hdr, {"R1 R2 R3 R4 header ", cur_tag}, req_bytes, exp_hdr);
        chk(req_len == exp_len, {"R2 len ", cur_tag}, req_len, exp_len);
        @(negedge clk);
        chk(req_valid === 1'b1 && req_bytes == exp_hdr, "R12 hold", req_bytes, exp_hdr);
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        @(negedge clk);
        if (rq.size() == 0) r = '{2'd0, 8'h00, 8'h00, -1};
        else r = rq.pop_front();
        rsp_valid = 1'b1; rsp_err = r.err; rsp_status = r.st; rsp_data = r.dat;
        last_rsp_cyc = cyc; next_gap = r.gap;
        @(negedge clk);
        rsp_valid = 1'b0;
      end else @(negedge clk);
    end
  end

  // monitor: scoreboard compare on done
  initial begin
    forever begin
      @(negedge clk);
      if (done === 1'b1) begin
        if (eq.size() == 0) chk(1'b0, "R5 unexpected done", 1, 0);
        else begin
          exp_t e;
          e = eq.pop_front();
          chk(result == e.res, {"result ", e.tag}, result, e.res);
          chk(rdata == e.rd, {"R11 rdata ", e.tag}, rdata, e.rd);
          chk(busy == 1'b0, "R5 busy low at done", busy, 0);
        end
      end
    end
  end

  function automatic logic [39:0] model_hdr(input logic [2:0] op, input logic [15:0] a,
                                            input logic [7:0] wd);
    logic [7:0] b2, b3, b4;
    b2 = op[0] ? 8'h10 : 8'h00;
    if (op[2] == 1'b0) b2 = b2 + 8'h40;
    if (op[1] | op[2]) b3 = 8'h30;
    else b3 = op[0] ? 8'h40 : 8'h50;
    b4 = op[0] ? 8'h00 : wd;
    return {b4, b3, b2, a[15:8], a[7:0]};
  endfunction

  task automatic push_rsp(input logic [1:0] err, input logic [7:0] st,
                          input logic [7:0] dat, input int gap);
    rsp_t r;
    r = '{err, st, dat, gap};
    rq.push_back(r);
  endtask

  task automatic issue(input logic [2:0] op, input logic [15:0] a, input logic [7:0] wd,
                       input logic [2:0] res, input logic [7:0] rd, input int n_att,
                       input string tag, input bit poke);
    exp_t e;
    exp_hdr = model_hdr(op, a, wd);
    exp_len = op[0] ? 3'd4 : 3'd5;
    e = '{res, rd, tag};
    eq.push_back(e);
    nreq = 0; next_gap = -1; cur_tag = tag;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy === 1'b1, {"R5 busy after accept ", tag}, busy, 1);
    if (poke) begin
      cmd_valid = 1'b1; cmd_addr = ~a; cmd_op = 3'b001; cmd_wdata = ~wd;
      @(negedge clk);
      cmd_valid = 1'b0;
    end
    while (done !== 1'b1) @(negedge clk);
    chk(nreq == n_att, {"R9 attempts ", tag}, nreq, n_att);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 0 && req_valid == 0 && done == 0, "reset outputs", {busy, req_valid, done}, 0);
    chk(result == 0 && rdata == 0, "reset result", {result, rdata}, 0);

    push_rsp(0, 8'h00, 8'h00, -1);
    issue(3'b000, 16'h1234, 8'h5A, 3'd0, 8'h00, 1, "R1 R2 plain write", 0);
    push_rsp(0, 8'h00, 8'hA5, -1);
    issue(3'b001, 16'h0050, 8'h00, 3'd0, 8'hA5, 1, "R8 R11 plain read", 0);
    push_rsp(0, 8'h00, 8'h3C, -1);
    issue(3'b011, 16'h00A0, 8'h00, 3'd0, 8'hA5, 1, "R3 R11 start read", 0);
    push_rsp(0, 8'h00, 8'h00, -1);
    issue(3'b100, 16'h8001, 8'h11, 3'd0, 8'hA5, 1, "R3 R4 stop write", 0);
    push_rsp(0, 8'h00, 8'h77, -1);
    issue(3'b101, 16'h0050, 8'h00, 3'd0, 8'hA5, 1, "R4 R11 stop read", 0);
    push_rsp(0, 8'h10, 8'h00, -1);
    issue(3'b000, 16'h0042, 8'h22, 3'd1, 8'hA5, 1, "R7 native nack", 0);
    push_rsp(0, 8'h20, 8'h00, GN); push_rsp(0, 8'h00, 8'h00, -1);
    issue(3'b000, 16'h0043, 8'h33, 3'd0, 8'hA5, 2, "R7 R10 R5 native defer", 1);
    push_rsp(0, 8'h80, 8'h00, GI); push_rsp(0, 8'h40, 8'h00, -1);
    issue(3'b001, 16'h0044, 8'h00, 3'd2, 8'hA5, 2, "R8 R10 i2c defer nack", 0);
    push_rsp(0, 8'h30, 8'h00, -1);
    issue(3'b000, 16'h0045, 8'h44, 3'd3, 8'hA5, 1, "R7 native invalid", 0);
    push_rsp(0, 8'hC0, 8'h00, -1);
    issue(3'b001, 16'h0046, 8'h00, 3'd3, 8'hA5, 1, "R8 i2c invalid", 0);
    push_rsp(1, 8'h00, 8'h00, 0); push_rsp(0, 8'h00, 8'h99, -1);
    issue(3'b001, 16'h0047, 8'h00, 3'd0, 8'h99, 2, "R6 busy retry", 0);
    push_rsp(2, 8'h00, 8'h00, -1);
    issue(3'b000, 16'h0048, 8'h55, 3'd4, 8'h99, 1, "R6 transport error", 0);
    for (int i = 0; i < MT; i++) push_rsp(1, 8'h00, 8'h00, (i == MT - 1) ? -1 : 0);
    issue(3'b000, 16'h0049, 8'h66, 3'd5, 8'h99, MT, "R9 busy give up", 0);
    for (int i = 0; i < MT; i++) push_rsp(0, 8'h20, 8'h00, (i == MT - 1) ? -1 : GN);
    issue(3'b001, 16'h004A, 8'h00, 3'd5, 8'h99, MT, "R9 defer give up", 0);

    repeat (4) @(negedge clk);
    chk(eq.size() == 0, "R5 all results seen", eq.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule